// File: doc/BRIEF.md
# Segmented DAC Cell Decoder

This block is the digital front end of a segmented current-steering DAC. It registers each binary input word and splits it into two fields. The upper field is turned into a thermometer code that enables unit current cells. Those cells turn on in a symmetric order that grows outward from the centre of the array, or in plain index order when a parameter selects it. The lower field drives binary-weighted cells directly.

The lower field goes through a dummy register stage whose latency equals that of the thermometer decoder, so both fields arrive together. A final bank of per-cell latches, all on one clock edge, re-registers every enable. From that bank each cell also gets a complementary pair of switch controls, one steering the current to the output and one to the dump node. The controls use make-before-break timing: during a transition both are asserted, and they are never both released.

Top module: `sdac_seg_decoder`

## Requirements
- R1: The low `IN_W-MSB_W` bits of the captured word drive `bin_en` directly. Bit j of `bin_en` enables the binary cell of weight 2^j.
- R2: The number of asserted bits in `therm_en` equals the value of the upper `MSB_W` bits of the word. This holds on every cycle.
- R3: With `ORDER = ORD_SYM`, unit cells are added in a fixed order. Index c = (N_UNIT-1)/2 comes first, then c-1, c+1, c-2, c+2, and so on. For 7 cells the 0-based order is 3, 2, 4, 1, 5, 0, 6.
- R4: With `ORDER = ORD_SEQ`, a code of n enables unit cells 0 to n-1.
- R5: A word captured from `din` at clock edge k appears on `therm_en`, `bin_en` and the switch controls after edge k+2. Both fields arrive in that same cycle.
- R6: For every cell, `sw_steer` and `sw_dump` are never both 0.
- R7: If a cell's enable has the same value on two consecutive cycles, then `sw_steer` equals the enable and `sw_dump` is its inverse. On the cycle an enable changes, both controls of that cell are 1.
- R8: The reset input is synchronous and active high. One edge with reset high clears every enable and every `sw_steer` bit, sets every `sw_dump` bit, and clears the input and decode registers.
- R9: The field split is set by parameters. A 3+2 configuration (7 unit cells, 2 binary cells) follows the same rules as the default 5+5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for all registers and cell latches |
| rst | input | 1 | Synchronous active-high reset |
| din | input | IN_W | Binary input word |
| therm_en | output | N_UNIT | Latched unit-cell enables, N_UNIT = 2^MSB_W - 1 |
| bin_en | output | IN_W-MSB_W | Latched binary-weighted cell enables |
| sw_steer | output | N_UNIT+IN_W-MSB_W | Per-cell output-path switch control; unit cells in the low bits, binary cells above |
| sw_dump | output | N_UNIT+IN_W-MSB_W | Per-cell dump-path switch control, same bit layout as `sw_steer` |

## Verification
Some properties are checked by the in-line assertions on every cycle. The unit-cell count must track the code captured two edges earlier, on both fields at once. The two switch controls must never both be low, and they must be complementary in steady state. The centre cell is always first in symmetric mode, and the enables are contiguous from index 0 in sequential mode. The exact cell pattern for each code can only be shown by the bench sweeps. Those sweeps cover every code, large jumps between codes, and a reset during streaming, and they compare against an outward-walk model and the literal 7-cell order list.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_SYM = 1'b1
    } order_e;

    // Position of unit cell p in the switch-on sequence (0 = first on).
    function automatic int unit_rank(input int p, input int n, input order_e ord);
        int c;
        c = (n - 1) / 2;
        if (ord == ORD_SEQ) return p;
        if (p == c)         return 0;
        if (p < c)          return 2 * (c - p) - 1;
        return 2 * (p - c);
    endfunction

endpackage

// File: rtl/sdac_therm_dec.sv
module sdac_therm_dec
    import sdac_pkg::*;
#(
    parameter int     MSB_W = 5,
    parameter order_e ORDER = ORD_SYM,
    localparam int    N_UNIT = (1 << MSB_W) - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MSB_W-1:0]  code,
    output logic [N_UNIT-1:0] therm_q
);

    logic [N_UNIT-1:0] therm_d;

    for (genvar p = 0; p < N_UNIT; p++) begin : g_unit
        localparam int             RANK   = unit_rank(p, N_UNIT, ORDER);
        localparam logic [MSB_W:0] RANK_V = RANK[MSB_W:0];
        assign therm_d[p] = ({1'b0, code} > RANK_V);
    end

    always_ff @(posedge clk) begin
        if (rst) therm_q <= '0;
        else     therm_q <= therm_d;
    end

    // R2: decoded population equals the code one edge earlier
    a_r2_count: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($countones(therm_q) == int'($past(code))));

endmodule

// File: rtl/sdac_lsb_delay.sv
module sdac_lsb_delay #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Dummy stage: same register depth as the thermometer decoder.
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    // R5: the dummy path delays by exactly one edge
    a_r5_dummy: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (q == $past(d)));

endmodule

// File: rtl/sdac_cell_latch.sv
module sdac_cell_latch #(
    parameter int N = 36
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] en_d,
    output logic [N-1:0] en_q,
    output logic [N-1:0] steer_q,
    output logic [N-1:0] dump_q
);

    for (genvar i = 0; i < N; i++) begin : g_cell
        logic en_r, steer_r, dump_r;

        // Make-before-break: a changing cell holds both paths for one cycle.
        always_ff @(posedge clk) begin
            if (rst) begin
                en_r    <= 1'b0;
                steer_r <= 1'b0;
                dump_r  <= 1'b1;
            end else begin
                en_r    <= en_d[i];
                steer_r <= en_d[i] | en_r;
                dump_r  <= ~en_d[i] | ~en_r;
            end
        end

        assign en_q[i]    = en_r;
        assign steer_q[i] = steer_r;
        assign dump_q[i]  = dump_r;
    end

    // R6: never both switches open
    a_r6_no_gap: assert property (@(posedge clk) disable iff (rst)
        &(steer_q | dump_q));

    // R7: complementary once the enable has settled
    a_r7_steady: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (en_q == $past(en_q))) |-> (steer_q == en_q && dump_q == ~en_q));

    // R8: reset clears enables and selects the dump path
    a_r8_reset: assert property (@(posedge clk)
        rst |=> (en_q == '0 && steer_q == '0 && dump_q == '1));

endmodule

// File: rtl/sdac_seg_decoder.sv
module sdac_seg_decoder
    import sdac_pkg::*;
#(
    parameter int     IN_W  = 10,
    parameter int     MSB_W = 5,
    parameter order_e ORDER = ORD_SYM,
    localparam int    LSB_W  = IN_W - MSB_W,
    localparam int    N_UNIT = (1 << MSB_W) - 1,
    localparam int    N_CELL = N_UNIT + LSB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IN_W-1:0]   din,
    output logic [N_UNIT-1:0] therm_en,
    output logic [LSB_W-1:0]  bin_en,
    output logic [N_CELL-1:0] sw_steer,
    output logic [N_CELL-1:0] sw_dump
);

    localparam int CENTER = (N_UNIT - 1) / 2;

    logic [IN_W-1:0]   din_q;
    logic [MSB_W-1:0]  msb_code;
    logic [LSB_W-1:0]  lsb_code;
    logic [N_UNIT-1:0] therm_s;
    logic [LSB_W-1:0]  lsb_s;
    logic [N_CELL-1:0] cell_en;

    always_ff @(posedge clk) begin
        if (rst) din_q <= '0;
        else     din_q <= din;
    end

    assign msb_code = din_q[IN_W-1 -: MSB_W];
    assign lsb_code = din_q[LSB_W-1:0];

    sdac_therm_dec #(.MSB_W(MSB_W), .ORDER(ORDER)) u_therm (
        .clk(clk), .rst(rst), .code(msb_code), .therm_q(therm_s)
    );

    sdac_lsb_delay #(.W(LSB_W)) u_lsb (
        .clk(clk), .rst(rst), .d(lsb_code), .q(lsb_s)
    );

    sdac_cell_latch #(.N(N_CELL)) u_latch (
        .clk(clk), .rst(rst), .en_d({lsb_s, therm_s}),
        .en_q(cell_en), .steer_q(sw_steer), .dump_q(sw_dump)
    );

    assign therm_en = cell_en[N_UNIT-1:0];
    assign bin_en   = cell_en[N_CELL-1:N_UNIT];

    // R5: both fields land two edges after the input register
    a_r5_latency: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |->
        (bin_en == $past(lsb_code, 2) && $countones(therm_en) == int'($past(msb_code, 2))));

    if (ORDER == ORD_SYM) begin : g_sym_chk
        // R3: the centre cell is always the first one on
        a_r3_center_first: assert property (@(posedge clk) disable iff (rst)
            (|therm_en) |-> therm_en[CENTER]);
    end else begin : g_seq_chk
        // R4: sequential enables form a contiguous run from cell 0
        a_r4_contiguous: assert property (@(posedge clk) disable iff (rst)
            ((therm_en + 1'b1) & therm_en) == '0);
    end

endmodule

// File: tb/sdac_seg_decoder_tb.sv
`timescale 1ns/1ps
module sdac_seg_decoder_tb_top;
    import sdac_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [9:0] din_a = '0;
    logic [4:0] din_s = '0;

    logic [30:0] t_a; logic [4:0] b_a; logic [35:0] s_a, d_a;
    logic [6:0]  t_b; logic [1:0] b_b; logic [8:0]  s_b, d_b;
    logic [6:0]  t_c; logic [1:0] b_c; logic [8:0]  s_c, d_c;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [9:0] ha [0:3];
    logic [4:0] hs [0:3];

    always #2.5 clk = ~clk;

    sdac_seg_decoder #(.IN_W(10), .MSB_W(5), .ORDER(ORD_SYM)) dut_i (
        .clk(clk), .rst(rst), .din(din_a), .therm_en(t_a), .bin_en(b_a),
        .sw_steer(s_a), .sw_dump(d_a));
    sdac_seg_decoder #(.IN_W(5), .MSB_W(3), .ORDER(ORD_SYM)) dut_sym7_i (
        .clk(clk), .rst(rst), .din(din_s), .therm_en(t_b), .bin_en(b_b),
        .sw_steer(s_b), .sw_dump(d_b));
    sdac_seg_decoder #(.IN_W(5), .MSB_W(3), .ORDER(ORD_SEQ)) dut_seq7_i (
        .clk(clk), .rst(rst), .din(din_s), .therm_en(t_c), .bin_en(b_c),
        .sw_steer(s_c), .sw_dump(d_c));

    // Outward walk from the centre, placing one cell at a time.
    function automatic logic [30:0] exp_sym31(input int n);
        logic [30:0] m = '0;
        int placed = 0;
        if (n > 0) begin m[15] = 1'b1; placed = 1; end
        for (int d = 1; d <= 15; d++) begin
            if (placed < n) begin m[15-d] = 1'b1; placed++; end
            if (placed < n) begin m[15+d] = 1'b1; placed++; end
        end
        return m;
    endfunction

    function automatic logic [6:0] exp_sym7(input int n);
        int ord [7] = '{3, 2, 4, 1, 5, 0, 6};
        logic [6:0] m = '0;
        for (int k = 0; k < n; k++) m[ord[k]] = 1'b1;
        return m;
    endfunction

    function automatic logic [6:0] exp_seq7(input int n);
        logic [6:0] m = '0;
        for (int k = 0; k < n; k++) m[k] = 1'b1;
        return m;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic check_outputs();
        logic [35:0] ca2, ca3;
        logic [8:0]  cb2, cb3, cc2, cc3;
        ca2 = {ha[2][4:0], exp_sym31(int'(ha[2][9:5]))};
        ca3 = {ha[3][4:0], exp_sym31(int'(ha[3][9:5]))};
        cb2 = {hs[2][1:0], exp_sym7(int'(hs[2][4:2]))};
        cb3 = {hs[3][1:0], exp_sym7(int'(hs[3][4:2]))};
        cc2 = {hs[2][1:0], exp_seq7(int'(hs[2][4:2]))};
        cc3 = {hs[3][1:0], exp_seq7(int'(hs[3][4:2]))};
        // R3 R5: symmetric pattern from the word two edges after capture
        chk(t_a == ca2[30:0], "R3", 64'(t_a), 64'(ca2[30:0]));
        chk($countones(t_a) == int'(ha[2][9:5]), "R2", 64'($countones(t_a)), 64'(ha[2][9:5]));
        chk(b_a == ha[2][4:0], "R1", 64'(b_a), 64'(ha[2][4:0]));
        chk(&(s_a | d_a), "R6", 64'(s_a | d_a), 64'h0f_ffff_ffff);
        chk(s_a == (ca2 | ca3), "R7 steer", 64'(s_a), 64'(ca2 | ca3));
        chk(d_a == (~ca2 | ~ca3), "R7 dump", 64'(d_a), 64'(~ca2 | ~ca3));
        // R9: 3+2 split, symmetric list 3,2,4,1,5,0,6
        chk(t_b == cb2[6:0], "R9 R3 list", 64'(t_b), 64'(cb2[6:0]));
        chk(b_b == hs[2][1:0], "R5 R9 lsb", 64'(b_b), 64'(hs[2][1:0]));
        chk(s_b == (cb2 | cb3) && d_b == (~cb2 | ~cb3), "R9 R7", 64'({s_b, d_b}), 64'({cb2 | cb3, ~cb2 | ~cb3}));
        chk(t_c == cc2[6:0], "R4", 64'(t_c), 64'(cc2[6:0]));
        chk(b_c == hs[2][1:0] && s_c == (cc2 | cc3) && d_c == (~cc2 | ~cc3), "R4 R6",
            64'({b_c, s_c}), 64'({hs[2][1:0], cc2 | cc3}));
    endtask

    // One cycle: check at the falling edge, then drive the next word.
    task automatic step(input logic [9:0] va, input logic [4:0] vs, input bit r);
        @(negedge clk);
        check_outputs();
        if (r) begin
            rst = 1'b1; din_a = '0; din_s = '0;
            for (int k = 0; k < 4; k++) begin ha[k] = '0; hs[k] = '0; end
        end else begin
            rst = 1'b0;
            for (int k = 3; k > 0; k--) begin ha[k] = ha[k-1]; hs[k] = hs[k-1]; end
            ha[0] = va; hs[0] = vs; din_a = va; din_s = vs;
        end
    endtask

    task automatic check_reset_state();
        @(negedge clk);
        chk(t_a == '0 && b_a == '0 && t_b == '0 && t_c == '0, "R8 enables", 64'({t_a, b_a}), 64'h0);
        chk(s_a == '0 && d_a == '1 && s_c == '0 && d_c == '1, "R8 switches", 64'({s_a, d_a}), 64'({36'h0, 36'hf_ffff_ffff}));
    endtask

    initial begin
        for (int k = 0; k < 4; k++) begin ha[k] = '0; hs[k] = '0; end
        check_reset_state();
        for (int i = 0; i < 3; i++) step('0, '0, 1'b1);
        // ascending sweep of every code
        for (int i = 0; i < 1024; i++) step(10'(i), 5'(i), 1'b0);
        // scattered codes with large jumps
        for (int i = 0; i < 512; i++) step(10'(i * 397 + 123), 5'(i * 13 + 7), 1'b0);
        // full-scale toggling
        for (int i = 0; i < 16; i++) step(i[0] ? 10'h3ff : 10'h000, i[0] ? 5'h1f : 5'h00, 1'b0);
        // reset in mid-stream, then recovery
        for (int i = 0; i < 8; i++) step(10'(i * 77 + 500), 5'(i * 5 + 3), 1'b0);
        step('0, '0, 1'b1);
        check_reset_state();
        step('0, '0, 1'b1);
        for (int i = 0; i < 40; i++) step(10'(1023 - i * 25), 5'(31 - i), 1'b0);
        for (int i = 0; i < 4; i++) step('0, '0, 1'b0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule